// File: doc/BRIEF.md
# Bidirectional Pin Boundary-Scan Cell

This block is the boundary-scan register segment for one bidirectional digital pin with a selectable pull-up. It sits in the pad ring between the core's port logic and the pad. In normal operation it passes the core's drive, direction and pull-up request straight to the pad. Under an external-test instruction it replaces them with values that were shifted in serially and then latched.

The segment holds three shift flops. The first carries the pull-up enable. The second carries the output control. The third stage is shared: it captures the pad's input level but updates the pad's output data. Output control, output data and input data therefore use two shift stages rather than three. All flops load on the data-register clock. Each shift flop feeds a level-sensitive update latch. The segment is chained through `scan_in` and `scan_out` with its neighbours, and the TAP controller that drives the control lines sits outside the block.

Top module: `bscan_bidir_cell`

## Requirements
- R1: The chain runs `scan_in` → pull-up stage → output-control stage → data stage, and `scan_out` is the data-stage flop, so a bit presented on `scan_in` appears on `scan_out` after exactly three `clock_dr` rising edges with `shift_dr` high.
- R2: On each `clock_dr` rising edge with `shift_dr` high, every stage takes the value of the stage before it, and the pull-up stage takes `scan_in`.
- R3: On a `clock_dr` rising edge with `shift_dr` low, the stages capture in parallel. The data stage takes `pad_in` directly, with no synchronising register. The output-control stage takes `dir_out`, and the pull-up stage takes the functional pull-up enable.
- R4: The functional pull-up enable is 1 only when `pull_dis` is 0, `dir_out` is 0 and `port_bit` is 1.
- R5: With `extest` low, `pad_oe` equals `dir_out`, `pad_out` equals `port_bit` and `pad_pue` equals the functional pull-up enable, all combinationally.
- R6: With `extest` high, `pad_pue`, `pad_oe` and `pad_out` show the update latches of the pull-up, output-control and data stages respectively.
- R7: The update latches are transparent while `update_dr` is high and hold while it is low, so shifting or capturing does not disturb the pads under `extest`.
- R8: `rst_n` low clears all flops and latches to 0. Selecting `extest` before any update therefore gives output disabled, pull-up off and output data 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clock_dr | input | 1 | Data-register clock; shift flops load on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of flops and latches |
| shift_dr | input | 1 | 1 = shift serially, 0 = parallel capture |
| update_dr | input | 1 | Update latches transparent while high |
| extest | input | 1 | 1 = pads driven from update latches |
| scan_in | input | 1 | Serial input from the previous cell |
| scan_out | output | 1 | Serial output to the next cell |
| pull_dis | input | 1 | Global pull-up disable from the core |
| dir_out | input | 1 | Core data-direction bit (1 = output) |
| port_bit | input | 1 | Core port data bit |
| pad_in | input | 1 | Raw level seen at the pad |
| pad_pue | output | 1 | Pull-up enable to the pad |
| pad_oe | output | 1 | Output enable to the pad |
| pad_out | output | 1 | Output data to the pad |

## Verification
The pad outputs under `extest` low are due in the same cycle as the core inputs. The latched pad values are due as soon as `update_dr` is high, without waiting for a clock edge. Stage contents and `scan_out` change one `clock_dr` edge after a shift or capture, so a serial bit reaches `scan_out` on the third edge. The bench drives inputs on the falling edge. It compares every output against a behavioural model once just before and once just after each rising edge, so both the combinational paths and the registered paths are sampled exactly in the cycle they are due.

// File: rtl/bscan_bidir_cell.sv
module bscan_bidir_cell (
  input  logic clock_dr,
  input  logic rst_n,
  input  logic shift_dr,
  input  logic update_dr,
  input  logic extest,
  input  logic scan_in,
  output logic scan_out,
  input  logic pull_dis,
  input  logic dir_out,
  input  logic port_bit,
  input  logic pad_in,
  output logic pad_pue,
  output logic pad_oe,
  output logic pad_out
);
  localparam int STAGES = 3;
  localparam int PUE = 2, OC = 1, DAT = 0;

  logic [STAGES-1:0] sr, upd, cap, nxt;
  logic func_pue;

  assign func_pue = ~pull_dis & ~dir_out & port_bit;
  assign cap      = {func_pue, dir_out, pad_in};
  assign nxt      = shift_dr ? {scan_in, sr[STAGES-1:1]} : cap;

  always_ff @(posedge clock_dr or negedge rst_n)
    if (!rst_n) sr <= '0;
    else        sr <= nxt;

  always_latch
    if (!rst_n)         upd <= '0;
    else if (update_dr) upd <= sr;

  assign scan_out = sr[DAT];
  assign pad_pue  = extest ? upd[PUE] : func_pue;
  assign pad_oe   = extest ? upd[OC]  : dir_out;
  assign pad_out  = extest ? upd[DAT] : port_bit;

  AST_SHIFT_ADVANCE: assert property (@(posedge clock_dr) disable iff (!rst_n)
    shift_dr |=> (sr[PUE] == $past(scan_in)) && (sr[OC] == $past(sr[PUE])) && (scan_out == $past(sr[OC]))); // R2
  AST_CAPTURE_PIN: assert property (@(posedge clock_dr) disable iff (!rst_n)
    !shift_dr |=> (scan_out == $past(pad_in)) && (sr[OC] == $past(dir_out))); // R3
  AST_PULLUP_INPUT_ONLY: assert property (@(posedge clock_dr) disable iff (!rst_n)
    (!extest && pad_pue) |-> (!pad_oe && !pull_dis)); // R4
  AST_EXTEST_HOLD: assert property (@(posedge clock_dr) disable iff (!rst_n)
    (extest && $past(extest) && !update_dr && !$past(update_dr)) |-> $stable({pad_pue, pad_oe, pad_out})); // R7
endmodule

// File: tb/tb_bscan_bidir_cell.sv
module tb_bscan_bidir_cell;
  logic clk = 0, rst_n = 0, shift_dr = 0, update_dr = 0, extest = 0, scan_in = 0;
  logic pull_dis = 0, dir_out = 0, port_bit = 0, pad_in = 0;
  logic scan_out, pad_pue, pad_oe, pad_out;
  int checks = 0, fails = 0;
  bit done = 0;
  bit [2:0] m_sr = 0, m_up = 0;  // [2] pull-up, [1] output control, [0] data

  always #5 clk = ~clk;

  bscan_bidir_cell dut (
    .clock_dr(clk), .rst_n(rst_n), .shift_dr(shift_dr), .update_dr(update_dr),
    .extest(extest), .scan_in(scan_in), .scan_out(scan_out), .pull_dis(pull_dis),
    .dir_out(dir_out), .port_bit(port_bit), .pad_in(pad_in),
    .pad_pue(pad_pue), .pad_oe(pad_oe), .pad_out(pad_out));

  function automatic bit fpue();
    return !pull_dis && !dir_out && port_bit;
  endfunction

  task automatic check(input string tag);
    bit [3:0] exp, act;
    if (!rst_n) begin m_sr = 0; m_up = 0; end
    else if (update_dr) m_up = m_sr;
    exp = {m_sr[0], extest ? m_up[2] : fpue(), extest ? m_up[1] : dir_out, extest ? m_up[0] : port_bit};
    act = {scan_out, pad_pue, pad_oe, pad_out};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {scan_out,pue,oe,out} actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit sh, input bit up, input bit ex, input bit si,
                      input bit pd, input bit dr, input bit pb, input bit pin, input string tag);
    shift_dr = sh; update_dr = up; extest = ex; scan_in = si;
    pull_dis = pd; dir_out = dr; port_bit = pb; pad_in = pin;
    #1 check(tag);
    @(posedge clk);
    if (rst_n) m_sr = sh ? {si, m_sr[2:1]} : {fpue(), dr, pin};
    #1 check(tag);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit [7:0] lfsr = 8'hA5;
    @(negedge clk);
    step(0, 1, 1, 1, 0, 1, 1, 1, "R8");
    step(1, 0, 1, 1, 0, 1, 1, 1, "R8");
    rst_n = 1;
    step(0, 0, 1, 0, 0, 1, 1, 1, "R8");
    for (int i = 0; i < 8; i++)
      step(1, 0, 0, 0, i[2], i[1], i[0], 0, "R4_R5");
    step(0, 0, 0, 0, 0, 1, 0, 1, "R3");
    step(0, 0, 0, 0, 0, 0, 1, 0, "R3");
    step(0, 0, 0, 0, 1, 0, 1, 1, "R3");
    step(1, 0, 0, 1, 0, 0, 0, 0, "R1");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R1");
    step(1, 0, 0, 1, 0, 0, 0, 0, "R1");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R1");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 1, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 1, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 1, 1, 0, 0, 0, 0, 0, "R6");
    step(1, 0, 1, 1, 0, 0, 0, 0, "R7");
    step(1, 0, 1, 1, 0, 0, 0, 0, "R7");
    step(0, 0, 1, 0, 0, 1, 1, 0, "R7");
    step(0, 1, 1, 0, 0, 1, 0, 1, "R6");
    step(1, 0, 0, 0, 1, 0, 1, 0, "R5");
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0], lfsr[1] & lfsr[6], lfsr[2], lfsr[3], lfsr[4] & lfsr[7], lfsr[5],
           lfsr[6], lfsr[7] ^ lfsr[0], "R2_R3_R6_R7");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule